// File: doc/BRIEF.md
# Execute-Stage Arithmetic Unit with Condition Flags

This block is the execute stage of a small in-order processor. A single 32-bit adder/logic unit computes the stage result `val_e_o` for every instruction class. For integer operations it carries out the selected function. For data moves, immediates, effective addresses and stack adjustment it is used only as an adder: it adds zero to pass an operand through, adds the displacement to a base, or moves the stack pointer by one word.

A three-bit flag register holds zero, sign and overflow. Only integer operations update it. A condition evaluator combines the stored flags with a condition code to produce `cnd_o`, which steers branches and conditional moves. The stack pointer value arrives on `val_b_i`. For a push, the decremented value on `val_e_o` is the memory write address. For a pop, memory is read at the old pointer while `val_e_o` carries the incremented value. The register update is done later, outside this block.

Top module: `exec_unit`

## Requirements
- R1: With `kind_i`=0 (integer op), `val_e_o` is val_b+val_a for `fun_i`=0, val_b−val_a for 1, val_b AND val_a for 2 and val_b XOR val_a for 3, combinationally in the same cycle.
- R2: `kind_i`=1 gives `val_e_o`=val_a, `kind_i`=2 gives val_c, `kind_i`=3 gives val_b+val_c, and `kind_i`=6 or 7 gives val_b.
- R3: `kind_i`=4 (push/call) gives `val_e_o`=val_b−4.
- R4: `kind_i`=5 (pop/return) gives `val_e_o`=val_b+4.
- R5: On the clock edge of an integer op, `flags_o` takes ZF (bit 2) = result is zero and SF (bit 1) = result bit 31.
- R6: Any `kind_i` other than 0 leaves `flags_o` unchanged.
- R7: OF (bit 0) is set on signed overflow of add or subtract and is cleared by AND and XOR.
- R8: `cnd_o` for `cond_i` 0..6 is: 1, (SF^OF)|ZF, SF^OF, ZF, ~ZF, ~(SF^OF), ~(SF^OF)&~ZF. For code 7 it is 0.
- R9: `cnd_o` is computed from the stored flags, so an integer op presented in the same cycle does not affect it until the next cycle.
- R10: Reset (`rst_ni` low) sets `flags_o` to ZF=1, SF=0, OF=0 (3'b100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kind_i | input | 3 | Instruction class |
| fun_i | input | 2 | Integer function select |
| cond_i | input | 3 | Branch/move condition code |
| val_a_i | input | 32 | Operand A |
| val_b_i | input | 32 | Operand B / stack pointer |
| val_c_i | input | 32 | Constant / displacement |
| val_e_o | output | 32 | Stage result |
| cnd_o | output | 1 | Condition outcome |
| flags_o | output | 3 | Stored flags {ZF, SF, OF} |

## Verification
Two functions can fall in the same cycle: a flag-setting integer op and a condition evaluation. The bench provokes this by presenting an integer op whose result would change the flags together with a condition that depends on them, for example equality right after a zero result with a nonzero new result. It judges `cnd_o` in that cycle against the flags held before the op, and checks in the next cycle that both the flags and `cnd_o` reflect the new result. Random sequences mix op classes so that this overlap recurs with varied flag values.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [2:0] {
    K_OP = 3'd0, K_MOVE = 3'd1, K_IMM = 3'd2, K_ADDR = 3'd3,
    K_PUSH = 3'd4, K_POP = 3'd5, K_PASS = 3'd6, K_PASS2 = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    F_ADD = 2'd0, F_SUB = 2'd1, F_AND = 2'd2, F_XOR = 2'd3
  } fun_e;

  typedef enum logic [2:0] {
    C_ALW = 3'd0, C_LE = 3'd1, C_LT = 3'd2, C_EQ = 3'd3,
    C_NE = 3'd4, C_GE = 3'd5, C_GT = 3'd6, C_NEV = 3'd7
  } cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;
endpackage

// File: rtl/exu_opsel.sv
module exu_opsel
  import exu_pkg::*;
#(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  kind_e        kind_i,
  input  fun_e         fun_i,
  input  logic [W-1:0] val_a_i,
  input  logic [W-1:0] val_b_i,
  input  logic [W-1:0] val_c_i,
  output logic [W-1:0] alu_a_o,
  output logic [W-1:0] alu_b_o,
  output fun_e         alu_fun_o,
  output logic         set_cc_o
);
  localparam logic [W-1:0] STEP_W = W'(STEP);

  always_comb begin
    alu_a_o   = '0;
    alu_b_o   = val_b_i;
    alu_fun_o = F_ADD;
    set_cc_o  = 1'b0;
    unique case (kind_i)
      K_OP: begin
        alu_a_o   = val_a_i;
        alu_fun_o = fun_i;
        set_cc_o  = 1'b1;
      end
      K_MOVE: begin
        alu_a_o = val_a_i;
        alu_b_o = '0;
      end
      K_IMM: begin
        alu_a_o = val_c_i;
        alu_b_o = '0;
      end
      K_ADDR: alu_a_o = val_c_i;
      K_PUSH: begin
        alu_a_o   = STEP_W;
        alu_fun_o = F_SUB;
      end
      K_POP:  alu_a_o = STEP_W;
      default: alu_a_o = '0;
    endcase
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  fun_e         fun_i,
  output logic [W-1:0] res_o,
  output flags_t       flags_o
);
  localparam int MSB = W - 1;

  logic ovf;

  always_comb begin
    ovf = 1'b0;
    unique case (fun_i)
      F_ADD: begin
        res_o = b_i + a_i;
        ovf   = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != b_i[MSB]);
      end
      F_SUB: begin
        res_o = b_i - a_i;
        ovf   = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != b_i[MSB]);
      end
      F_AND:   res_o = b_i & a_i;
      default: res_o = b_i ^ a_i;
    endcase
  end

  assign flags_o.zf = (res_o == '0);
  assign flags_o.sf = res_o[MSB];
  assign flags_o.of = ovf;
endmodule

// File: rtl/exu_cc.sv
module exu_cc
  import exu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   set_cc_i,
  input  flags_t nflags_i,
  input  cond_e  cond_i,
  output flags_t flags_o,
  output logic   cnd_o
);
  flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= '{zf: 1'b1, sf: 1'b0, of: 1'b0};
    else if (set_cc_i) flags_q <= nflags_i;
  end

  logic lt;
  assign lt = flags_q.sf ^ flags_q.of;

  always_comb begin
    unique case (cond_i)
      C_ALW:   cnd_o = 1'b1;
      C_LE:    cnd_o = lt | flags_q.zf;
      C_LT:    cnd_o = lt;
      C_EQ:    cnd_o = flags_q.zf;
      C_NE:    cnd_o = ~flags_q.zf;
      C_GE:    cnd_o = ~lt;
      C_GT:    cnd_o = ~lt & ~flags_q.zf;
      default: cnd_o = 1'b0;
    endcase
  end

  assign flags_o = flags_q;

  a_r6_cc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_cc_i |=> $stable(flags_q));
  a_r9_eq_ne_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == C_EQ) |-> (cnd_o == flags_o.zf));
  a_r8_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == C_ALW) |-> cnd_o);
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exu_pkg::*;
#(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   kind_i,
  input  logic [1:0]   fun_i,
  input  logic [2:0]   cond_i,
  input  logic [W-1:0] val_a_i,
  input  logic [W-1:0] val_b_i,
  input  logic [W-1:0] val_c_i,
  output logic [W-1:0] val_e_o,
  output logic         cnd_o,
  output logic [2:0]   flags_o
);
  localparam logic [W-1:0] STEP_W = W'(STEP);

  logic [W-1:0] alu_a, alu_b;
  fun_e         alu_fun;
  logic         set_cc;
  flags_t       nflags, flags_q;

  exu_opsel #(.W(W), .STEP(STEP)) u_opsel (
    .kind_i   (kind_e'(kind_i)),
    .fun_i    (fun_e'(fun_i)),
    .val_a_i  (val_a_i),
    .val_b_i  (val_b_i),
    .val_c_i  (val_c_i),
    .alu_a_o  (alu_a),
    .alu_b_o  (alu_b),
    .alu_fun_o(alu_fun),
    .set_cc_o (set_cc)
  );

  exu_alu #(.W(W)) u_alu (
    .a_i    (alu_a),
    .b_i    (alu_b),
    .fun_i  (alu_fun),
    .res_o  (val_e_o),
    .flags_o(nflags)
  );

  exu_cc u_cc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_cc_i(set_cc),
    .nflags_i(nflags),
    .cond_i  (cond_e'(cond_i)),
    .flags_o (flags_q),
    .cnd_o   (cnd_o)
  );

  assign flags_o = flags_q;

  a_r3_push_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 3'd4) |-> (val_e_o == val_b_i - STEP_W));
  a_r4_pop_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 3'd5) |-> (val_e_o == val_b_i + STEP_W));
  a_r7_logic_clears_of: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 3'd0 && fun_i[1]) |=> !flags_o[0]);
  a_r5_zero_sets_zf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 3'd0 && val_e_o == '0) |=> flags_o[2]);
endmodule

// File: tb/sim_exec_unit.sv
module sim_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  kind = '0;
  logic [1:0]  fun = '0;
  logic [2:0]  cond = '0;
  logic [31:0] va = '0, vb = '0, vc = '0;
  logic [31:0] val_e;
  logic        cnd;
  logic [2:0]  flags;

  int n_run = 0;
  int n_fail = 0;
  logic [2:0] m_flags;

  always #10 clk = ~clk;

  exec_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .kind_i(kind), .fun_i(fun), .cond_i(cond),
    .val_a_i(va), .val_b_i(vb), .val_c_i(vc),
    .val_e_o(val_e), .cnd_o(cnd), .flags_o(flags)
  );

  function automatic logic [31:0] f_val(logic [2:0] k, logic [1:0] f,
                                        logic [31:0] a, logic [31:0] b, logic [31:0] c);
    case (k)
      3'd0: case (f)
              2'd0: return b + a;
              2'd1: return b - a;
              2'd2: return b & a;
              default: return b ^ a;
            endcase
      3'd1: return a;
      3'd2: return c;
      3'd3: return b + c;
      3'd4: return b - 32'd4;
      3'd5: return b + 32'd4;
      default: return b;
    endcase
  endfunction

  function automatic logic [2:0] f_flags(logic [1:0] f, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    logic o;
    r = f_val(3'd0, f, a, b, 32'd0);
    o = 1'b0;
    if (f == 2'd0) o = (a[31] == b[31]) && (r[31] != a[31]);
    if (f == 2'd1) o = (a[31] != b[31]) && (r[31] != b[31]);
    return {r == 32'd0, r[31], o};
  endfunction

  function automatic logic f_cnd(logic [2:0] c, logic [2:0] fl);
    logic z, s, o;
    {z, s, o} = fl;
    case (c)
      3'd0: return 1'b1;
      3'd1: return (s ^ o) | z;
      3'd2: return s ^ o;
      3'd3: return z;
      3'd4: return !z;
      3'd5: return !(s ^ o);
      3'd6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] k);
    case (k)
      3'd0: return "R1";
      3'd4: return "R3";
      3'd5: return "R4";
      default: return "R2";
    endcase
  endfunction

  // one cycle: drive at negedge, check comb outputs, then model the edge
  task automatic step(logic [2:0] k, logic [1:0] f, logic [2:0] c,
                      logic [31:0] a, logic [31:0] b, logic [31:0] cc);
    @(negedge clk);
    kind = k; fun = f; cond = c; va = a; vb = b; vc = cc;
    #2;
    chk(tag_of(k), val_e, f_val(k, f, a, b, cc));
    chk((k == 3'd0) ? "R9" : "R8", {31'd0, cnd}, {31'd0, f_cnd(c, m_flags)});
    chk((k == 3'd0) ? "R5" : "R6", {29'd0, flags}, {29'd0, m_flags});
    @(posedge clk);
    if (k == 3'd0) m_flags = f_flags(f, a, b);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_flags = 3'b100;
    #25;
    chk("R10", {29'd0, flags}, 32'd4);
    @(negedge clk);
    rst_n = 1'b1;
    // every condition against reset flags
    for (int i = 0; i < 8; i++) step(3'd6, 2'd0, 3'(i), 32'd0, 32'd7, 32'd0);
    // add overflow: 0x7fffffff + 1
    step(3'd0, 2'd0, 3'd3, 32'd1, 32'h7fffffff, 32'd0);
    chk("R7", {31'd0, m_flags[0]}, 32'd1);
    step(3'd6, 2'd0, 3'd2, 32'd0, 32'd0, 32'd0);
    // AND clears OF
    step(3'd0, 2'd2, 3'd1, 32'hffffffff, 32'h80000000, 32'd0);
    step(3'd6, 2'd0, 3'd5, 32'd0, 32'd0, 32'd0);
    // sub overflow: 0x80000000 - 1
    step(3'd0, 2'd1, 3'd0, 32'd1, 32'h80000000, 32'd0);
    step(3'd6, 2'd0, 3'd6, 32'd0, 32'd0, 32'd0);
    // XOR to zero, then same-cycle op with eq condition (R9)
    step(3'd0, 2'd3, 3'd4, 32'h1234, 32'h1234, 32'd0);
    step(3'd0, 2'd0, 3'd3, 32'd5, 32'd6, 32'd0);
    step(3'd1, 2'd0, 3'd3, 32'd9, 32'd0, 32'd0);
    // stack boundaries
    step(3'd4, 2'd0, 3'd0, 32'd0, 32'd0, 32'd0);
    step(3'd5, 2'd0, 3'd0, 32'd0, 32'hfffffffc, 32'd0);
    step(3'd3, 2'd1, 3'd0, 32'd0, 32'h100, 32'hfffffff0);
    step(3'd2, 2'd3, 3'd0, 32'd0, 32'd0, 32'hdeadbeef);
    step(3'd7, 2'd0, 3'd7, 32'd0, 32'h55, 32'd0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      logic [31:0] a, b;
      k = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom);
      a = ($urandom % 4 == 0) ? 32'h80000000 >> ($urandom % 2) : $urandom;
      b = ($urandom % 5 == 0) ? a : $urandom;
      step(k, 2'($urandom), 3'($urandom), a, b, $urandom);
    end
    @(negedge clk);
    #2;
    chk("R5", {29'd0, flags}, {29'd0, m_flags});
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule